// File: doc/BRIEF.md
# In-Group Store-to-Load Overlap Detector

This block sits beside an instruction-group former and remembers the stores placed into the group currently being built. Each recorded store keeps its access size and its two address operands: a first operand that is either a constant displacement or a register tag, and a second operand that is a base register tag. When the former offers a load as the next member of the group, the block answers in the same cycle. It reports whether that load may read bytes an earlier store of the same group writes. The caller treats a raised `hazard` as a request to pad with a no-op rather than a hard stall.

Addresses are never computed. A conflict is found in one of two ways. The first is operand identity, in the same order or with the two operands swapped. The second applies when both accesses name the same base and both carry constant displacements: the two byte ranges are then compared. The caller decodes opcodes into a small size code. The table empties whenever the group closes.

Top module: `stld_guard`

## Requirements
- R1: Size code 0, 1, 2, 3, 4 means an access of 1, 2, 4, 8, 16 bytes respectively; codes 5 to 7 are treated as 16 bytes.
- R2: A load conflicts with a recorded store when the load's first operand equals the store's first operand and the load's second operand equals the store's second operand.
- R3: A load also conflicts when its first operand equals the store's second operand and its second operand equals the store's first operand.
- R4: When the second operands are equal and both first operands are constants, and the store displacement is below the load displacement (unsigned), the accesses conflict if store displacement plus store size exceeds the load displacement.
- R5: Under the same operand condition, with the load displacement at or below the store displacement, the accesses conflict if load displacement plus load size exceeds the store displacement.
- R6: `hazard` is combinational and can be 1 only while `ldCheck` is 1 and at least one store is recorded; it is the OR of the conflicts against all recorded stores.
- R7: A `groupEnd` pulse empties the table at that clock edge; a store strobed in the same cycle as `groupEnd` is discarded.
- R8: The table holds at most 4 stores; a store strobed while 4 are already recorded is ignored.
- R9: An operand is 18 bits: bit 17 valid, bit 16 is-constant, bits 15:0 value. Two operands are equal only when both are valid and their is-constant bits and values agree; a displacement comparison requires both first operands valid with is-constant set.
- R10: A store is recorded at the clock edge where `stCommit` is 1, so a load presented in the same cycle is not compared with it.
- R11: After reset the table is empty and `hazard` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| groupEnd | input | 1 | The current group closes at this edge; empties the table |
| stCommit | input | 1 | Record the presented store at this edge |
| stSize | input | 3 | Store size code |
| stOpA | input | 18 | Store first operand (displacement or register tag) |
| stOpB | input | 18 | Store second operand (base register tag) |
| ldCheck | input | 1 | A load candidate is presented this cycle |
| ldSize | input | 3 | Load size code |
| ldOpA | input | 18 | Load first operand |
| ldOpB | input | 18 | Load second operand |
| hazard | output | 1 | Load may touch bytes written by a recorded store |

## Verification
The assertions assume `groupEnd` and `stCommit` are single-cycle strobes sampled at the clock edge. They also assume that `hazard` is looked at only while the load operands are stable within a cycle. The bench drives every input at the falling edge and samples `hazard` shortly afterwards. It therefore never relies on a same-edge race between a store being recorded and a load being checked. The main sweep uses a single shared base register and walks every pair of constant displacements and size codes in a small window, plus a pair near the top of the 16-bit range. Each group in that sweep holds exactly one store, so the count limit is exercised only by a dedicated case.

// File: rtl/stld_pkg.sv
package stld_pkg;

  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic clrAll;     // empty every entry this edge
    logic wrEn;       // write the entry selected by the index
    logic anyStored;  // at least one entry is live
  } stld_strb_t;

  // Size code to byte count; codes beyond 4 saturate at 16 bytes.
  function automatic logic [4:0] sizeBytes(input logic [2:0] code);
    logic [4:0] res;
    if (code > 3'd4) res = 5'd16;
    else             res = 5'd1 << code;
    return res;
  endfunction

endpackage

// File: rtl/stld_ctrl.sv
module stld_ctrl
  import stld_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             groupEnd,
  input  logic             stCommit,
  output stld_strb_t       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [CNT_W-1:0] storeCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic             roomLeft;

  assign roomLeft = (cnt < CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)                       cnt <= '0;
    else if (groupEnd)               cnt <= '0;
    else if (stCommit && roomLeft)   cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    strb.clrAll    = groupEnd;
    strb.wrEn      = stCommit && !groupEnd && roomLeft;
    strb.anyStored = (cnt != '0);
  end

  assign wrIdx    = IDX_W'(cnt);
  assign storeCnt = cnt;

endmodule

// File: rtl/stld_match.sv
module stld_match #(
  parameter int VAL_W = 16,
  localparam int OP_W  = VAL_W + 2,
  localparam int SUM_W = VAL_W + 1
) (
  input  logic [OP_W-1:0] sOpA,
  input  logic [OP_W-1:0] sOpB,
  input  logic [4:0]      sBytes,
  input  logic [OP_W-1:0] lOpA,
  input  logic [OP_W-1:0] lOpB,
  input  logic [4:0]      lBytes,
  output logic            hit
);

  function automatic logic sameOp(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
    return x[OP_W-1] && y[OP_W-1] && (x[OP_W-2:0] == y[OP_W-2:0]);
  endfunction

  logic             inOrder, swapped, baseEq, bothConst, rangeHit;
  logic [SUM_W-1:0] sOff, lOff, sEnd, lEnd;

  always_comb begin
    inOrder   = sameOp(lOpA, sOpA) && sameOp(lOpB, sOpB);
    swapped   = sameOp(lOpA, sOpB) && sameOp(lOpB, sOpA);
    baseEq    = sameOp(lOpB, sOpB);
    bothConst = sOpA[OP_W-1] && sOpA[OP_W-2] && lOpA[OP_W-1] && lOpA[OP_W-2];
    sOff      = {1'b0, sOpA[VAL_W-1:0]};
    lOff      = {1'b0, lOpA[VAL_W-1:0]};
    sEnd      = sOff + SUM_W'(sBytes);
    lEnd      = lOff + SUM_W'(lBytes);
    if (sOff < lOff) rangeHit = (sEnd > lOff);
    else             rangeHit = (lEnd > sOff);
    hit = inOrder || swapped || (baseEq && bothConst && rangeHit);
  end

endmodule

// File: rtl/stld_table.sv
module stld_table
  import stld_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int VAL_W  = 16,
  localparam int OP_W  = VAL_W + 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stld_strb_t       strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [2:0]       stSize,
  input  logic [OP_W-1:0]  stOpA,
  input  logic [OP_W-1:0]  stOpB,
  input  logic             ldCheck,
  input  logic [2:0]       ldSize,
  input  logic [OP_W-1:0]  ldOpA,
  input  logic [OP_W-1:0]  ldOpB,
  output logic             hazard
);

  logic [OP_W-1:0] entA   [DEPTH];
  logic [OP_W-1:0] entB   [DEPTH];
  logic [4:0]      entSz  [DEPTH];
  logic [DEPTH-1:0] entLive;
  logic [DEPTH-1:0] entHit;
  logic [4:0]      ldBytes;

  assign ldBytes = sizeBytes(ldSize);

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrAll) begin
        entLive[g] <= 1'b0;
      end else if (strb.wrEn && (wrIdx == IDX_W'(g))) begin
        entLive[g] <= 1'b1;
        entA[g]    <= stOpA;
        entB[g]    <= stOpB;
        entSz[g]   <= sizeBytes(stSize);
      end
    end

    stld_match #(.VAL_W(VAL_W)) match_i (
      .sOpA  (entA[g]),
      .sOpB  (entB[g]),
      .sBytes(entSz[g]),
      .lOpA  (ldOpA),
      .lOpB  (ldOpB),
      .lBytes(ldBytes),
      .hit   (entHit[g])
    );
  end

  assign hazard = ldCheck && strb.anyStored && |(entHit & entLive);

endmodule

// File: rtl/stld_guard.sv
module stld_guard
  import stld_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int VAL_W = 16,
  localparam int OP_W  = VAL_W + 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            groupEnd,
  input  logic            stCommit,
  input  logic [2:0]      stSize,
  input  logic [OP_W-1:0] stOpA,
  input  logic [OP_W-1:0] stOpB,
  input  logic            ldCheck,
  input  logic [2:0]      ldSize,
  input  logic [OP_W-1:0] ldOpA,
  input  logic [OP_W-1:0] ldOpB,
  output logic            hazard
);

  stld_strb_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic [CNT_W-1:0] storeCnt;

  stld_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .groupEnd(groupEnd),
    .stCommit(stCommit),
    .strb    (strb),
    .wrIdx   (wrIdx),
    .storeCnt(storeCnt)
  );

  stld_table #(.DEPTH(DEPTH), .VAL_W(VAL_W)) table_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrIdx  (wrIdx),
    .stSize (stSize),
    .stOpA  (stOpA),
    .stOpB  (stOpB),
    .ldCheck(ldCheck),
    .ldSize (ldSize),
    .ldOpA  (ldOpA),
    .ldOpB  (ldOpB),
    .hazard (hazard)
  );

endmodule

// File: rtl/stld_checker.sv
module stld_checker #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             groupEnd,
  input logic             stCommit,
  input logic             ldCheck,
  input logic             hazard,
  input logic [CNT_W-1:0] storeCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  AST_GROUP_END_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    groupEnd |=> (storeCnt == '0)); // R7

  AST_FULL_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (stCommit && !groupEnd && storeCnt == CNT_MAX) |=> (storeCnt == CNT_MAX)); // R8

  AST_COMMIT_ADDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stCommit && !groupEnd && storeCnt < CNT_MAX) |=> (storeCnt == $past(storeCnt) + CNT_W'(1))); // R10

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!stCommit && !groupEnd) |=> $stable(storeCnt)); // R7

  AST_NO_LOAD_NO_HAZARD: assert property (@(posedge clk) disable iff (!rstN)
    !ldCheck |-> !hazard); // R6

  AST_EMPTY_NO_HAZARD: assert property (@(posedge clk) disable iff (!rstN)
    (storeCnt == '0) |-> !hazard); // R6

endmodule

bind stld_guard stld_checker #(.DEPTH(DEPTH)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .groupEnd(groupEnd),
  .stCommit(stCommit),
  .ldCheck (ldCheck),
  .hazard  (hazard),
  .storeCnt(storeCnt)
);

// File: tb/stld_guard_tb_top.sv
`timescale 1ns/1ps
module stld_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        groupEnd = 1'b0, stCommit = 1'b0, ldCheck = 1'b0;
  logic [2:0]  stSize = '0, ldSize = '0;
  logic [17:0] stOpA = '0, stOpB = '0, ldOpA = '0, ldOpB = '0;
  logic        hazard;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  stld_guard dut_i (
    .clk(clk), .rstN(rstN), .groupEnd(groupEnd), .stCommit(stCommit),
    .stSize(stSize), .stOpA(stOpA), .stOpB(stOpB),
    .ldCheck(ldCheck), .ldSize(ldSize), .ldOpA(ldOpA), .ldOpB(ldOpB),
    .hazard(hazard)
  );

  // operand fields per R9: bit17 valid, bit16 constant, 15:0 value
  function automatic logic [17:0] op(input bit v, input bit c, input int val);
    return {v, c, 16'(val)};
  endfunction
  function automatic logic [17:0] rg(input int t);  return op(1, 0, t); endfunction
  function automatic logic [17:0] cn(input int k);  return op(1, 1, k); endfunction

  function automatic int bytesOf(input int code); // R1
    return (code > 4) ? 16 : (1 << code);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: hazard=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic endGroup();
    @(negedge clk); groupEnd = 1'b1;
    @(negedge clk); groupEnd = 1'b0;
  endtask

  task automatic putStore(input logic [17:0] a, input logic [17:0] b, input int code);
    @(negedge clk);
    stOpA = a; stOpB = b; stSize = 3'(code); stCommit = 1'b1;
    @(negedge clk); stCommit = 1'b0;
  endtask

  task automatic probe(input string req, input logic [17:0] a, input logic [17:0] b,
                       input int code, input logic exp);
    @(negedge clk);
    ldOpA = a; ldOpB = b; ldSize = 3'(code); ldCheck = 1'b1;
    #1 check(req, hazard, exp);
    ldCheck = 1'b0;
  endtask

  initial begin
    // R11: reset state, load presented while in reset and right after
    ldOpA = rg(1); ldOpB = rg(2); ldCheck = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R11 in reset", hazard, 1'b0);
    ldCheck = 1'b0;
    @(negedge clk); rstN = 1'b1;
    probe("R11 empty after reset", rg(1), rg(2), 2, 1'b0);

    // R2 same-order register operands
    endGroup(); putStore(rg(3), rg(4), 2);
    probe("R2 same order", rg(3), rg(4), 2, 1'b1);
    probe("R2 other base", rg(3), rg(5), 2, 1'b0);
    // R6 load strobe low keeps hazard low
    @(negedge clk); ldOpA = rg(3); ldOpB = rg(4); ldCheck = 1'b0;
    #1 check("R6 no load strobe", hazard, 1'b0);

    // R3 swapped operands
    endGroup(); putStore(rg(7), rg(9), 0);
    probe("R3 swapped", rg(9), rg(7), 0, 1'b1);

    // R9 constant flag and valid bit take part in equality
    endGroup(); putStore(cn(6), rg(9), 2);
    probe("R9 const vs reg", rg(6), rg(9), 2, 1'b0);
    probe("R9 invalid base", cn(6), op(0, 0, 9), 2, 1'b0);
    endGroup(); putStore(op(0, 1, 6), rg(9), 2);
    probe("R9 invalid store offset", cn(6), rg(9), 2, 1'b0);

    // R7 group end empties
    endGroup(); putStore(rg(3), rg(4), 2);
    endGroup();
    probe("R7 cleared", rg(3), rg(4), 2, 1'b0);
    // R7 store in same cycle as group end is discarded
    putStore(rg(3), rg(4), 2);
    @(negedge clk);
    groupEnd = 1'b1; stOpA = rg(11); stOpB = rg(12); stCommit = 1'b1;
    @(negedge clk); groupEnd = 1'b0; stCommit = 1'b0;
    probe("R7 old entry gone", rg(3), rg(4), 2, 1'b0);
    probe("R7 same-cycle store dropped", rg(11), rg(12), 2, 1'b0);

    // R10 store not visible in its own commit cycle
    endGroup();
    @(negedge clk);
    stOpA = rg(20); stOpB = rg(21); stSize = 3'd2; stCommit = 1'b1;
    ldOpA = rg(20); ldOpB = rg(21); ldSize = 3'd2; ldCheck = 1'b1;
    #1 check("R10 same cycle", hazard, 1'b0);
    @(negedge clk); stCommit = 1'b0; ldCheck = 1'b0;
    probe("R10 next cycle", rg(20), rg(21), 2, 1'b1);

    // R8 capacity of four
    endGroup();
    for (int i = 0; i < 6; i++) putStore(rg(30 + i), rg(40 + i), 2);
    probe("R8 first entry", rg(30), rg(40), 2, 1'b1);
    probe("R8 fourth entry", rg(33), rg(43), 2, 1'b1);
    probe("R8 fifth ignored", rg(34), rg(44), 2, 1'b0);
    probe("R8 sixth ignored", rg(35), rg(45), 2, 1'b0);

    // R1 saturating size codes
    for (int c = 5; c < 8; c++) begin
      endGroup(); putStore(cn(0), rg(2), c);
      probe("R1 code>4 covers byte 15", cn(15), rg(2), 0, 1'b1);
      probe("R1 code>4 stops at 16", cn(16), rg(2), 0, 1'b0);
    end

    // R4/R5 unsigned top of range
    endGroup(); putStore(cn(16'hFFF0), rg(2), 4);
    probe("R4 wrap-free top", cn(16'hFFFF), rg(2), 0, 1'b1);
    endGroup(); putStore(cn(16'hFFFF), rg(2), 0);
    probe("R5 wrap-free top", cn(16'hFFF8), rg(2), 3, 1'b1);
    probe("R5 short of top", cn(16'hFFF0), rg(2), 3, 1'b0);

    // R4/R5/R1 sweep over displacements and sizes, shared base
    for (int s = 0; s < 20; s++)
      for (int sc = 0; sc < 5; sc++) begin
        endGroup(); putStore(cn(s), rg(2), sc);
        for (int l = 0; l < 20; l++)
          for (int lc = 0; lc < 5; lc++) begin
            int lo, hi;
            lo = (s > l) ? s : l;
            hi = ((s + bytesOf(sc)) < (l + bytesOf(lc))) ? (s + bytesOf(sc)) : (l + bytesOf(lc));
            probe((s < l) ? "R4 sweep" : "R5 sweep", cn(l), rg(2), lc, logic'(lo < hi));
          end
      end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule